// File: doc/BRIEF.md
# Codec Control Port Register Slave

This block is the control-port slave of an audio codec. A host reaches it over a four-wire serial link made of an active-low select, a serial clock, a data-in line and a data-out line. Each transaction is sixteen clock periods long. It carries a direction flag, a seven-bit register address and one data byte. The block holds a small register file of codec settings and drives every setting as a plain output, so that the analog and filtering logic can use the values directly. Those settings are power enables, line-in and line-out gains, mixer routing, serial-format selection and reset control.

The serial pins are asynchronous to the block. They are oversampled by the system clock through two-flop synchronizers, and clock edges are detected in the system clock domain. The serial clock idles high. The host changes data-in while the clock is high, and the block captures it on the falling edge. The block updates data-out after each rising edge, so the host can sample it on the next falling edge. Each high phase and each low phase of the serial clock must last at least four system clocks. The data flow is a fixed register access protocol with no valid/ready back-pressure: the host paces every bit with the serial clock, and a write takes effect without any acknowledgement.

Top module: `codec_ctl_spi`

## Requirements
- R1: The first bit of a frame is the direction flag (0 = write, 1 = read). It is followed by seven address bits, most significant first, and then eight data bits, most significant first. A write takes effect only after the sixteenth bit has been captured.
- R2: Data-in is captured on falling edges of the serial clock. Data-out changes only in the system clock after a detected rising edge, or when select is inactive.
- R3: The implemented registers, with their writable bits, are: 0x00 power enables (bits 7:0), 0x01 left line-in gain (bits 4:0), 0x02 right line-in gain (bits 4:0), 0x05 left line-out gain (bits 5:0), 0x06 right line-out gain (bits 5:0), 0x08 mixer control (bits 5:0: four input enables and two invert bits), 0x0A format control (bits 5:0) and 0x10 reset control (bits 2:0). Unused upper bits are stored and read back as zero.
- R4: During a read, the eight bits of the addressed register appear on data-out in the data phase, most significant first, one bit after each rising edge. Data-out is low outside that phase.
- R5: After the block reset, power enables, line-out gains and mixer control are 0x00, both line-in gains are 0x05, format control is 0x02 and reset control is 0x03.
- R6: If select is released before sixteen bits have been captured, the transaction is aborted and no register changes.
- R7: A write to an unimplemented address changes nothing, and a read from one returns 0x00.
- R8: Writing reset-control bit 0 as 0 returns every other register to its reset value on the next system clock. The other registers stay at their reset values, and writes to them are ignored, until bit 0 is written back to 1.
- R9: Serial clocks beyond the sixteenth bit in one select period are ignored, and a read frame changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial link |
| rst_n | input | 1 | Asynchronous active-low block reset |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_sck | input | 1 | Serial clock, idle high |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host, low when not returning read data |
| pwr_en | output | 8 | Power enable bits (register 0x00) |
| line_in_gain_l | output | 5 | Left line-in gain (0x01) |
| line_in_gain_r | output | 5 | Right line-in gain (0x02) |
| line_out_gain_l | output | 6 | Left line-out gain (0x05) |
| line_out_gain_r | output | 6 | Right line-out gain (0x06) |
| mix_ctl | output | 6 | Mixer input enables and output inverts (0x08) |
| fmt_ctl | output | 6 | Format, dither, de-emphasis and word-length fields (0x0A) |
| reset_ctl | output | 3 | Reset control; bit 0 is the active-low register reset (0x10) |

## Verification
Directed frames write recognisable patterns such as 0xA5 and all-ones to each register. Reading each value back separates correct bit order and masking from shifted or truncated fields. Frames cut off after ten and after fifteen bits, frames stretched to eighteen bits, and accesses to an unmapped address show whether commit is tied exactly to the sixteenth falling edge. A soft-reset sequence writes values, clears the reset bit, tries a write while reset is held and then releases the bit. This tells a clean hold apart from a one-shot clear. Seeded random frames follow, mixing reads and writes with abort lengths over both mapped and unmapped addresses, and every frame is compared against a bench model of the register map.

// File: rtl/codec_ctl_pkg.sv
package codec_ctl_pkg;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 8;
  localparam int HDR_W    = 1 + ADDR_W;
  localparam int FRAME_W  = HDR_W + DATA_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam int NUM_REGS = 8;
  localparam int RST_IDX  = 7;

  typedef struct packed {
    logic [7:0] pwr;
    logic [4:0] lig_l;
    logic [4:0] lig_r;
    logic [5:0] log_l;
    logic [5:0] log_r;
    logic [5:0] mix;
    logic [5:0] fmt;
    logic [2:0] rstc;
  } ctl_regs_t;

  function automatic logic [ADDR_W-1:0] reg_addr(input int idx);
    case (idx)
      0:       return 7'h00;
      1:       return 7'h01;
      2:       return 7'h02;
      3:       return 7'h05;
      4:       return 7'h06;
      5:       return 7'h08;
      6:       return 7'h0A;
      default: return 7'h10;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_mask(input int idx);
    case (idx)
      0:       return 8'hFF;
      1, 2:    return 8'h1F;
      3, 4:    return 8'h3F;
      5, 6:    return 8'h3F;
      default: return 8'h07;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reg_reset(input int idx);
    case (idx)
      1, 2:    return 8'h05;
      6:       return 8'h02;
      7:       return 8'h03;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/codec_ctl_sync.sv
module codec_ctl_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/codec_ctl_frame.sv
module codec_ctl_frame
  import codec_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sdo,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sck_rise
);
  logic                  sck_d;
  logic                  sck_fall;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_W-2:0]    shreg;
  logic                  rd_q;
  logic [DATA_W-1:0]     out_sh;

  // edge detection on the synchronized serial clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b1;
    else        sck_d <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  // after the header, the low bits of the shifter hold the address
  assign rd_addr = shreg[ADDR_W-1:0];

  // input side: capture on falling edges, commit a write on the last bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      shreg   <= '0;
      rd_q    <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (cs_n_s) begin
        cnt  <= '0;
        rd_q <= 1'b0;
      end else if (sck_fall && (cnt < CNT_W'(FRAME_W))) begin
        shreg <= {shreg[FRAME_W-3:0], sdi_s};
        cnt   <= cnt + 1'b1;
        if (cnt == '0) rd_q <= sdi_s;
        if ((cnt == CNT_W'(FRAME_W-1)) && !rd_q) begin
          wr_en   <= 1'b1;
          wr_addr <= shreg[FRAME_W-3:DATA_W-1];
          wr_data <= {shreg[DATA_W-2:0], sdi_s};
        end
      end
    end
  end

  // output side: shift read data after rising edges in the data phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo    <= 1'b0;
      out_sh <= '0;
    end else if (cs_n_s) begin
      sdo <= 1'b0;
    end else if (sck_rise) begin
      if (rd_q && (cnt == CNT_W'(HDR_W))) begin
        sdo    <= rd_data[DATA_W-1];
        out_sh <= {rd_data[DATA_W-2:0], 1'b0};
      end else if (rd_q && (cnt > CNT_W'(HDR_W)) && (cnt < CNT_W'(FRAME_W))) begin
        sdo    <= out_sh[DATA_W-1];
        out_sh <= {out_sh[DATA_W-2:0], 1'b0};
      end else begin
        sdo <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
  import codec_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output ctl_regs_t         ctl
);
  logic [DATA_W-1:0] q [NUM_REGS];
  logic              soft_rst_n;

  assign soft_rst_n = q[RST_IDX][0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] RADDR = reg_addr(g);
    localparam logic [DATA_W-1:0] RMASK = reg_mask(g);
    localparam logic [DATA_W-1:0] RRST  = reg_reset(g);
    if (g == RST_IDX) begin : g_rstc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q[g] <= RRST;
        else if (wr_en && wr_addr == RADDR)  q[g] <= wr_data & RMASK;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q[g] <= RRST;
        else if (!soft_rst_n)                q[g] <= RRST;
        else if (wr_en && wr_addr == RADDR)  q[g] <= wr_data & RMASK;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_addr == reg_addr(i)) rd_data = q[i];
    end
  end

  assign ctl.pwr   = q[0];
  assign ctl.lig_l = q[1][4:0];
  assign ctl.lig_r = q[2][4:0];
  assign ctl.log_l = q[3][5:0];
  assign ctl.log_r = q[4][5:0];
  assign ctl.mix   = q[5][5:0];
  assign ctl.fmt   = q[6][5:0];
  assign ctl.rstc  = q[7][2:0];
endmodule

// File: rtl/codec_ctl_spi.sv
module codec_ctl_spi
  import codec_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_cs_n,
  input  logic       spi_sck,
  input  logic       spi_sdi,
  output logic       spi_sdo,
  output logic [7:0] pwr_en,
  output logic [4:0] line_in_gain_l,
  output logic [4:0] line_in_gain_r,
  output logic [5:0] line_out_gain_l,
  output logic [5:0] line_out_gain_r,
  output logic [5:0] mix_ctl,
  output logic [5:0] fmt_ctl,
  output logic [2:0] reset_ctl
);
  logic [2:0]        pins_s;
  logic              sck_s;
  logic              cs_idle;
  logic              sdi_s;
  logic              sck_rise;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  ctl_regs_t         ctl;

  codec_ctl_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b110)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_sck, spi_cs_n, spi_sdi}),
    .q     (pins_s)
  );

  assign sck_s   = pins_s[2];
  assign cs_idle = pins_s[1];
  assign sdi_s   = pins_s[0];

  codec_ctl_frame i_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (sck_s),
    .cs_n_s   (cs_idle),
    .sdi_s    (sdi_s),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .sdo      (spi_sdo),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sck_rise (sck_rise)
  );

  codec_ctl_regs i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .ctl     (ctl)
  );

  assign pwr_en          = ctl.pwr;
  assign line_in_gain_l  = ctl.lig_l;
  assign line_in_gain_r  = ctl.lig_r;
  assign line_out_gain_l = ctl.log_l;
  assign line_out_gain_r = ctl.log_r;
  assign mix_ctl         = ctl.mix;
  assign fmt_ctl         = ctl.fmt;
  assign reset_ctl       = ctl.rstc;
endmodule

// File: rtl/codec_ctl_spi_chk.sv
module codec_ctl_spi_chk
  import codec_ctl_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      cs_idle,
  input logic      sck_rise,
  input logic      wr_en,
  input logic      spi_sdo,
  input ctl_regs_t ctl
);
  // R4: no data driven while select is inactive
  p_sdo_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !spi_sdo);

  // R2: data-out moves only after a rising edge or on release of select
  p_sdo_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_sdo) |-> ($past(sck_rise) || $past(cs_idle)));

  // R1: one commit per frame
  p_wr_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R8: soft reset forces other registers to their reset values
  p_soft_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.rstc[0] |=> (ctl.pwr == 8'h00 && ctl.lig_l == 5'h05 &&
                      ctl.lig_r == 5'h05 && ctl.fmt == 6'h02 && ctl.mix == 6'h00));

  // R6: without a committed write the register file is unchanged
  p_no_write_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && ctl.rstc[0]) |=> $stable(ctl));
endmodule

bind codec_ctl_spi codec_ctl_spi_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_idle  (cs_idle),
  .sck_rise (sck_rise),
  .wr_en    (wr_en),
  .spi_sdo  (spi_sdo),
  .ctl      (ctl)
);

// File: tb/test_codec_ctl_spi.sv
module test_codec_ctl_spi;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WD_CYCLES  = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_sck = 1'b1;
  logic       spi_sdi = 1'b0;
  logic       spi_sdo;
  logic [7:0] pwr_en;
  logic [4:0] line_in_gain_l, line_in_gain_r;
  logic [5:0] line_out_gain_l, line_out_gain_r, mix_ctl, fmt_ctl;
  logic [2:0] reset_ctl;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] m [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_ctl_spi i_codec_ctl_spi (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .pwr_en(pwr_en),
    .line_in_gain_l(line_in_gain_l), .line_in_gain_r(line_in_gain_r),
    .line_out_gain_l(line_out_gain_l), .line_out_gain_r(line_out_gain_r),
    .mix_ctl(mix_ctl), .fmt_ctl(fmt_ctl), .reset_ctl(reset_ctl)
  );

  function automatic bit is_impl(input logic [6:0] a);
    return a == 7'h00 || a == 7'h01 || a == 7'h02 || a == 7'h05 ||
           a == 7'h06 || a == 7'h08 || a == 7'h0A || a == 7'h10;
  endfunction

  function automatic logic [7:0] mask_of(input logic [6:0] a);
    case (a)
      7'h00:        return 8'hFF;
      7'h01, 7'h02: return 8'h1F;
      7'h10:        return 8'h07;
      default:      return is_impl(a) ? 8'h3F : 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_of(input logic [6:0] a);
    case (a)
      7'h01, 7'h02: return 8'h05;
      7'h0A:        return 8'h02;
      7'h10:        return 8'h03;
      default:      return 8'h00;
    endcase
  endfunction

  task automatic model_reset_others();
    for (int a = 0; a < 128; a++) if (a != 16) m[a] = rst_of(7'(a));
  endtask

  task automatic model_write(input logic [6:0] a, input logic [7:0] d);
    if (a == 7'h10) begin
      m[16] = d & 8'h07;
      if (!m[16][0]) model_reset_others();
    end else if (is_impl(a) && m[16][0]) begin
      m[a] = d & mask_of(a);
    end
  endtask

  function automatic logic [44:0] exp_out();
    return {m[0], m[1][4:0], m[2][4:0], m[5][5:0], m[6][5:0],
            m[8][5:0], m[10][5:0], m[16][2:0]};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check(req, 64'({pwr_en, line_in_gain_l, line_in_gain_r, line_out_gain_l,
                    line_out_gain_r, mix_ctl, fmt_ctl, reset_ctl}), 64'(exp_out()));
  endtask

  // one select period with nbits serial clocks; model updated per the requirements
  task automatic xfer(input logic rw, input logic [6:0] a, input logic [7:0] d,
                      input int nbits, output logic [7:0] rd);
    logic [15:0] fr;
    fr = {rw, a, d};
    rd = '0;
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_sdi = (i < 16) ? fr[15-i] : 1'($urandom_range(0, 1));
      wait_clk(HALF);
      if (i >= 8 && i < 16) rd = {rd[6:0], spi_sdo};
      spi_sck = 1'b0;
      wait_clk(HALF);
      spi_sck = 1'b1;
    end
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    spi_sdi  = 1'b0;
    wait_clk(HALF);
    if (!rw && nbits >= 16) model_write(a, d);
  endtask

  function automatic logic [7:0] exp_read(input logic [6:0] a);
    return is_impl(a) ? m[a] : 8'h00;
  endfunction

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input string req);
    logic [7:0] rd;
    xfer(1'b0, a, d, 16, rd);
    check_outputs(req);
    check({req, " sdo low"}, 64'(spi_sdo), 64'(0));
  endtask

  task automatic rd_chk(input logic [6:0] a, input string req);
    logic [7:0] rd;
    logic [7:0] e;
    e = exp_read(a);
    xfer(1'b1, a, 8'h00, 16, rd);
    check(req, 64'(rd), 64'(e));
  endtask

  initial begin : watchdog
    wait_clk(WD_CYCLES);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    void'($urandom(32'h00C0_DE55));
    for (int a = 0; a < 128; a++) m[a] = rst_of(7'(a));
    m[16] = 8'h03;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R5 reset state at the ports and through reads
    check_outputs("R5 reset values");
    check("R4 idle sdo", 64'(spi_sdo), 64'(0));
    rd_chk(7'h01, "R5 read line-in gain reset");
    rd_chk(7'h0A, "R5 read format reset");

    // R1/R4 basic write and read back, bit order
    wr(7'h00, 8'hA5, "R1 write power");
    rd_chk(7'h00, "R4 read power A5");
    wr(7'h08, 8'h5A, "R1 write mixer");
    rd_chk(7'h08, "R4 read mixer");

    // R3 masking of unused bits
    wr(7'h01, 8'hFF, "R3 line-in mask");
    rd_chk(7'h01, "R3 line-in reads 1F");
    wr(7'h06, 8'hFF, "R3 line-out mask");
    wr(7'h10, 8'hFF, "R3 reset ctl mask");
    rd_chk(7'h10, "R3 reset ctl reads 07");

    // R6 aborted frames
    xfer(1'b0, 7'h00, 8'h3C, 10, rd);
    check_outputs("R6 abort after 10 bits");
    xfer(1'b0, 7'h00, 8'h3C, 15, rd);
    check_outputs("R6 abort after 15 bits");
    rd_chk(7'h00, "R6 power unchanged");

    // R7 unimplemented address
    wr(7'h03, 8'hFF, "R7 write unmapped");
    rd_chk(7'h03, "R7 read unmapped zero");
    rd_chk(7'h7F, "R7 read top address zero");

    // R9 extra clocks and reads do not disturb registers
    xfer(1'b0, 7'h02, 8'h11, 18, rd);
    check_outputs("R9 18-clock write");
    xfer(1'b1, 7'h02, 8'hFF, 20, rd);
    check("R9 read in long frame", 64'(rd), 64'(m[2]));
    check_outputs("R9 read changes nothing");

    // R8 soft reset hold and release
    wr(7'h0A, 8'h3F, "R8 set format");
    wr(7'h10, 8'h02, "R8 soft reset asserted");
    wr(7'h00, 8'hFF, "R8 write ignored while held");
    rd_chk(7'h00, "R8 read held power");
    wr(7'h10, 8'h03, "R8 soft reset released");
    wr(7'h00, 8'h81, "R8 write after release");

    // seeded random frames against the model
    for (int k = 0; k < 200; k++) begin
      logic [6:0] a;
      logic [7:0] d;
      logic [7:0] e;
      logic       rw;
      int         nb;
      int         sel;
      sel = $urandom_range(0, 99);
      a   = (sel < 75) ? (($urandom_range(0, 1) != 0) ? 7'h10 :
              7'(($urandom_range(0, 6) == 0) ? 0 : $urandom_range(0, 10)))
            : 7'($urandom_range(0, 127));
      d   = 8'($urandom_range(0, 255));
      if (a == 7'h10 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
      rw  = 1'($urandom_range(0, 1));
      sel = $urandom_range(0, 99);
      nb  = (sel < 10) ? $urandom_range(1, 15) : (sel < 15) ? $urandom_range(17, 20) : 16;
      e   = exp_read(a);
      xfer(rw, a, d, nb, rd);
      check_outputs("R3 random frame register map");
      if (rw && nb >= 16) check("R4 random read data", 64'(rd), 64'(e));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule